// File: doc/BRIEF.md
# Filtered Quadrature Front End

This block sits between an incremental position encoder and a position counter. It takes the raw A, B and index lines, which are asynchronous, and resynchronises them to the system clock. In the quadrature modes it cleans them with a small digital glitch filter and decodes the A/B phase sequence. It then emits one-cycle up and down count pulses and a one-cycle index pulse. The counter that accumulates these pulses lives elsewhere.

The filter advances on a filter tick. The tick comes from an external enable that can optionally be halved inside the block. The decode resolution is one, two or four counts per full quadrature cycle. A bypass mode treats A as a plain count clock and B as a direction level, and skips the filter. An index is accepted in quadrature mode only while the filtered A and B are equal. In bypass mode the index needs no such condition. A count-enable input gates the count pulses.

Top module: `qdec_front`

## Requirements
- R1: The 2-bit `mode_i` selects the operation: 2'b00 direction/clock bypass, 2'b01 x1, 2'b10 x2, 2'b11 x4 quadrature decoding.
- R2: In x4 mode every single-step change of the filtered {A,B} state yields one pulse. The forward order 00→10→11→01→00 gives `up_o` and the reverse order gives `dn_o`.
- R3: In x2 mode only steps where filtered A changes produce a pulse, so one full cycle gives two pulses.
- R4: In x1 mode one full cycle gives exactly one pulse. Forward counts on 00→10 and reverse counts on 10→00.
- R5: A filtered change in which A and B flip together (a double step) produces no count pulse.
- R6: A filtered line takes a new level only after the synchronised raw level has been sampled equal on two consecutive filter ticks. A one-clock glitch is therefore dropped when a tick occurs every clock.
- R7: With `fdiv2_i` = 0 every `ftick_i` is a filter tick. With `fdiv2_i` = 1 only every second `ftick_i` is one, so a two-clock pulse passes at divide-by-1 and is rejected at divide-by-2.
- R8: In bypass mode each rising edge of the synchronised, unfiltered A gives one pulse. It is `up_o` when B is high and `dn_o` when B is low, and even a one-clock A pulse counts.
- R9: While `cnt_en_i` is low no count pulse is produced.
- R10: In a quadrature mode an index pulse is emitted once when the active filtered index begins to coincide with filtered A equal to filtered B. An active index while A differs from B gives nothing.
- R11: `idx_pol_i` = 1 makes the index active high and `idx_pol_i` = 0 makes it active low.
- R12: In bypass mode the index is taken from the synchronised line without filtering and without regard to A and B.
- R13: `up_o`, `dn_o` and `idx_o` are registered one-cycle pulses, `up_o` and `dn_o` are never high together, and all outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ftick_i | input | 1 | Filter clock enable |
| fdiv2_i | input | 1 | 1: halve the filter tick rate |
| mode_i | input | 2 | Decode mode (R1 encoding) |
| idx_pol_i | input | 1 | Index active level |
| cnt_en_i | input | 1 | Count pulse enable |
| a_i | input | 1 | Raw encoder channel A (asynchronous) |
| b_i | input | 1 | Raw encoder channel B (asynchronous) |
| idx_i | input | 1 | Raw encoder index (asynchronous) |
| up_o | output | 1 | One-cycle up count pulse |
| dn_o | output | 1 | One-cycle down count pulse |
| idx_o | output | 1 | One-cycle qualified index pulse |

## Verification
The assertions check four properties on every cycle:
- up and down pulses never coincide;
- no count pulse follows a cycle with count enable low;
- an index pulse never lasts two cycles;
- a quadrature count always stems from a filtered state change of exactly one bit, which enforces the double-step rule.

Only the scenario bench can show the following behaviours, because each depends on a sequence of stimulus and an expected list of events:
- the decode direction and the pulse count per cycle at each resolution;
- glitch rejection and the prescale effect on pulse width;
- index qualification against the A/B state, and its polarity;
- the unfiltered bypass path.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    QM_DIRCLK = 2'b00,
    QM_X1     = 2'b01,
    QM_X2     = 2'b10,
    QM_X4     = 2'b11
  } qmode_e;

  // Position of an {A,B} state along the forward Gray sequence 00,10,11,01
  function automatic logic [1:0] gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '{default: '0};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdec_prescale.sv
module qdec_prescale (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic div2_i,
  output logic tick_o
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst)         phase <= 1'b0;
    else if (tick_i) phase <= ~phase;
  end

  assign tick_o = tick_i & (~div2_i | phase);
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic samp_r;
    logic filt_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        samp_r <= 1'b0;
        filt_r <= 1'b0;
      end else if (tick) begin
        samp_r <= raw[gi];
        if (raw[gi] == samp_r) filt_r <= raw[gi];
      end
    end

    assign filt[gi] = filt_r;
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cnt_en,
  input  logic       fa,
  input  logic       fb,
  input  logic       sa,
  input  logic       sb,
  output logic       up,
  output logic       dn
);
  logic [1:0] prev_ab;
  logic       prev_sa;
  logic [1:0] step;
  logic       fwd, rev, a_chg;
  logic       up_c, dn_c;

  always_comb begin
    step  = gray_pos(fa, fb) - gray_pos(prev_ab[1], prev_ab[0]);
    fwd   = (step == 2'd1);
    rev   = (step == 2'd3);
    a_chg = fa ^ prev_ab[1];
    up_c  = 1'b0;
    dn_c  = 1'b0;
    case (qmode_e'(mode))
      QM_DIRCLK: begin
        up_c = sa & ~prev_sa & sb;
        dn_c = sa & ~prev_sa & ~sb;
      end
      QM_X1: begin
        up_c = fwd & a_chg & ~fb;
        dn_c = rev & a_chg & ~fb;
      end
      QM_X2: begin
        up_c = fwd & a_chg;
        dn_c = rev & a_chg;
      end
      default: begin
        up_c = fwd;
        dn_c = rev;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ab <= 2'b00;
      prev_sa <= 1'b0;
      up      <= 1'b0;
      dn      <= 1'b0;
    end else begin
      prev_ab <= {fa, fb};
      prev_sa <= sa;
      up      <= cnt_en & up_c;
      dn      <= cnt_en & dn_c;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic pol,
  input  logic idx_f,
  input  logic idx_s,
  input  logic fa,
  input  logic fb,
  output logic pulse
);
  logic act_f, act_s, qual, qual_q;

  always_comb begin
    act_f = pol ? idx_f : ~idx_f;
    act_s = pol ? idx_s : ~idx_s;
    qual  = bypass ? act_s : (act_f & (fa == fb));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      qual_q <= qual;
      pulse  <= qual & ~qual_q;
    end
  end
endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ftick_i,
  input  logic       fdiv2_i,
  input  logic [1:0] mode_i,
  input  logic       idx_pol_i,
  input  logic       cnt_en_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       idx_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       idx_o
);
  localparam int NIN = 3;
  localparam int IA  = 0;
  localparam int IB  = 1;
  localparam int IX  = 2;

  logic [NIN-1:0] raw_s;
  logic [NIN-1:0] raw_f;
  logic           ftick;
  logic [1:0]     filt_ab;
  logic           bypass;

  assign bypass  = (qmode_e'(mode_i) == QM_DIRCLK);
  assign filt_ab = {raw_f[IA], raw_f[IB]};

  qdec_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({idx_i, b_i, a_i}),
    .q   (raw_s)
  );

  qdec_prescale u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_i (ftick_i),
    .div2_i (fdiv2_i),
    .tick_o (ftick)
  );

  qdec_filter #(.W(NIN)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .tick (ftick),
    .raw  (raw_s),
    .filt (raw_f)
  );

  qdec_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_i),
    .cnt_en (cnt_en_i),
    .fa     (raw_f[IA]),
    .fb     (raw_f[IB]),
    .sa     (raw_s[IA]),
    .sb     (raw_s[IB]),
    .up     (up_o),
    .dn     (dn_o)
  );

  qdec_index u_idx (
    .clk    (clk),
    .rst    (rst),
    .bypass (bypass),
    .pol    (idx_pol_i),
    .idx_f  (raw_f[IX]),
    .idx_s  (raw_s[IX]),
    .fa     (raw_f[IA]),
    .fb     (raw_f[IB]),
    .pulse  (idx_o)
  );
endmodule

// File: rtl/qdec_front_chk.sv
module qdec_front_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       cnt_en_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       idx_o,
  input logic [1:0] fab
);
  AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o)); // R13

  AST_NO_COUNT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (up_o || dn_o) |-> $past(cnt_en_i)); // R9

  AST_IDX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    idx_o |=> !idx_o); // R10

  AST_SINGLE_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((up_o || dn_o) && ($past(mode_i) != 2'b00))
      |-> ($countones($past(fab) ^ $past(fab, 2)) == 1)); // R5
endmodule

bind qdec_front qdec_front_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .cnt_en_i (cnt_en_i),
  .up_o     (up_o),
  .dn_o     (dn_o),
  .idx_o    (idx_o),
  .fab      (filt_ab)
);

// File: tb/test_qdec_front.sv
`timescale 1ns/1ps
module test_qdec_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ftick_i = 1'b1;
  logic       fdiv2_i = 1'b0;
  logic [1:0] mode_i = 2'b11;
  logic       idx_pol_i = 1'b1;
  logic       cnt_en_i = 1'b1;
  logic       a_i = 1'b0;
  logic       b_i = 1'b0;
  logic       idx_i = 1'b0;
  logic       up_o, dn_o, idx_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R13";
  int    exp_q[$];
  string req_q[$];

  localparam int EV_UP = 0, EV_DN = 1, EV_IX = 2;

  always #2.5 clk = ~clk;

  qdec_front i_qdec_front (
    .clk(clk), .rst(rst), .ftick_i(ftick_i), .fdiv2_i(fdiv2_i),
    .mode_i(mode_i), .idx_pol_i(idx_pol_i), .cnt_en_i(cnt_en_i),
    .a_i(a_i), .b_i(b_i), .idx_i(idx_i),
    .up_o(up_o), .dn_o(dn_o), .idx_o(idx_o)
  );

  function automatic string ev_name(int e);
    return (e == EV_UP) ? "up" : (e == EV_DN) ? "dn" : "idx";
  endfunction

  task automatic push_ev(int e, string req);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic got_ev(int e);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s: got %s, expected no event", cur_req, ev_name(e));
    end else begin
      int    x = exp_q.pop_front();
      string r = req_q.pop_front();
      if (x != e) begin
        n_bad++;
        $display("FAIL %s: got %s, expected %s", r, ev_name(e), ev_name(x));
      end
    end
  endtask

  // Monitor: sample between edges, pop the scoreboard in port order
  always @(negedge clk) begin
    if (!rst) begin
      if (up_o)  got_ev(EV_UP);
      if (dn_o)  got_ev(EV_DN);
      if (idx_o) got_ev(EV_IX);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(string req);
    wait_clk(12);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d events missing, expected 0 missing (next %s)",
               req, exp_q.size(), ev_name(exp_q[0]));
      exp_q.delete();
      req_q.delete();
    end
  endtask

  task automatic step_ab(logic a, logic b);
    a_i = a; b_i = b;
    wait_clk(8);
  endtask

  task automatic idx_pulse(logic lvl, int w);
    idx_i = lvl;
    wait_clk(w);
    idx_i = ~lvl;
    wait_clk(10);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R13 reset state
    n_chk++;
    if ({up_o, dn_o, idx_o} !== 3'b000) begin
      n_bad++;
      $display("FAIL R13: outputs %b after reset, expected 000", {up_o, dn_o, idx_o});
    end
    wait_clk(10);

    // R2 / R1: x4 forward two cycles, then reverse two cycles
    cur_req = "R2"; mode_i = 2'b11;
    for (int c = 0; c < 2; c++) begin
      push_ev(EV_UP, "R2"); step_ab(1, 0);
      push_ev(EV_UP, "R2"); step_ab(1, 1);
      push_ev(EV_UP, "R2"); step_ab(0, 1);
      push_ev(EV_UP, "R2"); step_ab(0, 0);
    end
    settle("R2");
    for (int c = 0; c < 2; c++) begin
      push_ev(EV_DN, "R2"); step_ab(0, 1);
      push_ev(EV_DN, "R2"); step_ab(1, 1);
      push_ev(EV_DN, "R2"); step_ab(1, 0);
      push_ev(EV_DN, "R2"); step_ab(0, 0);
    end
    settle("R2");

    // R3: x2
    cur_req = "R3"; mode_i = 2'b10;
    push_ev(EV_UP, "R3"); step_ab(1, 0);
    step_ab(1, 1);
    push_ev(EV_UP, "R3"); step_ab(0, 1);
    step_ab(0, 0);
    step_ab(0, 1);
    push_ev(EV_DN, "R3"); step_ab(1, 1);
    step_ab(1, 0);
    push_ev(EV_DN, "R3"); step_ab(0, 0);
    settle("R3");

    // R4: x1
    cur_req = "R4"; mode_i = 2'b01;
    push_ev(EV_UP, "R4"); step_ab(1, 0);
    step_ab(1, 1); step_ab(0, 1); step_ab(0, 0);
    step_ab(0, 1); step_ab(1, 1);
    push_ev(EV_DN, "R4"); step_ab(1, 0);
    step_ab(0, 0);
    settle("R4");

    // R5: double steps in x4 give nothing
    cur_req = "R5"; mode_i = 2'b11;
    step_ab(1, 1);
    step_ab(0, 0);
    settle("R5");

    // R6: one-clock glitch on A is dropped
    cur_req = "R6";
    a_i = 1'b1; wait_clk(1); a_i = 1'b0;
    settle("R6");
    idx_pulse(1'b1, 1);
    settle("R6");

    // R9: count enable low suppresses counting
    cur_req = "R9"; cnt_en_i = 1'b0;
    step_ab(1, 0); step_ab(1, 1); step_ab(0, 1); step_ab(0, 0);
    settle("R9");
    cnt_en_i = 1'b1;

    // R8: bypass mode, one-clock A pulses count, B sets direction
    cur_req = "R8"; mode_i = 2'b00;
    b_i = 1'b1; wait_clk(6);
    for (int k = 0; k < 3; k++) begin
      push_ev(EV_UP, "R8");
      a_i = 1'b1; wait_clk(1); a_i = 1'b0; wait_clk(4);
    end
    b_i = 1'b0; wait_clk(6);
    for (int k = 0; k < 2; k++) begin
      push_ev(EV_DN, "R8");
      a_i = 1'b1; wait_clk(1); a_i = 1'b0; wait_clk(4);
    end
    settle("R8");

    // R12: bypass index, unfiltered, with A != B
    cur_req = "R12";
    b_i = 1'b1; wait_clk(8);
    push_ev(EV_IX, "R12"); idx_pulse(1'b1, 1);
    b_i = 1'b0; wait_clk(8);
    settle("R12");

    // R10: quadrature index qualified by A == B
    cur_req = "R10"; mode_i = 2'b11;
    wait_clk(4);
    push_ev(EV_IX, "R10"); idx_pulse(1'b1, 6);
    push_ev(EV_UP, "R10"); step_ab(1, 0);
    idx_pulse(1'b1, 6);
    push_ev(EV_DN, "R10"); step_ab(0, 0);
    settle("R10");

    // R11: switch to active-low index without spurious events
    cur_req = "R11"; cnt_en_i = 1'b0;
    step_ab(1, 0);
    idx_i = 1'b1; wait_clk(8);
    idx_pol_i = 1'b0; wait_clk(4);
    step_ab(0, 0);
    cnt_en_i = 1'b1;
    settle("R11");
    push_ev(EV_IX, "R11"); idx_pulse(1'b0, 6);
    settle("R11");

    // R7: prescale, two-clock pulse passes at /1, rejected at /2
    cur_req = "R7";
    push_ev(EV_IX, "R7"); idx_pulse(1'b0, 2);
    settle("R7");
    fdiv2_i = 1'b1; wait_clk(4);
    idx_pulse(1'b0, 2);
    settle("R7");
    push_ev(EV_IX, "R7"); idx_pulse(1'b0, 6);
    settle("R7");

    // R1: x4 again after all mode changes, one step each way
    cur_req = "R1"; fdiv2_i = 1'b0; mode_i = 2'b11;
    push_ev(EV_UP, "R1"); step_ab(1, 0);
    push_ev(EV_DN, "R1"); step_ab(0, 0);
    settle("R1");

    done = 1'b1;
    summary();
  end
endmodule